// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Processor Core

This block is a minimal 32-bit processor that retires one instruction on every rising clock edge. It holds its own program counter, a 32-entry register file, an ALU steered by a two-stage decode, and separate word-wide instruction and data arrays. It supports nine instructions: word load and store, add, subtract, AND, OR, signed set-on-less-than, branch-if-equal and jump. Branch and jump targets are formed from PC+4.

A host fills both arrays through a preload port. The core does not advance while that port writes. Once reset is released, the program runs out of instruction memory. Two observation ports show one register and one data word at a time, so the results can be inspected after the run.

Top module: `rcore_top`

## Requirements
- R1: A synchronous active-high `rst` sets the PC to 0 and clears every register of the register file. Memory contents survive reset.
- R2: Each non-branching instruction advances the PC by exactly 4. Instruction memory is indexed by PC bits [MEM_AW+1:2].
- R3: When opcode [31:26] is 0, the function field [5:0] selects the operation: 100000 add, 100010 subtract, 100100 AND, 100101 OR. The result is written to register rd [15:11], with operands rs [25:21] and rt [20:16].
- R4: Function 101010 writes 1 to rd when rs is less than rt as a signed value, and writes 0 otherwise.
- R5: Opcode 35 loads and opcode 43 stores a data word at address rs plus the sign-extended [15:0], indexed by address bits [MEM_AW+1:2]. A load writes rt. A store never writes the register file.
- R6: Opcode 4 compares rs and rt. When they are equal, the next PC is PC+4 plus the sign-extended [15:0] shifted left by 2. When they differ, the next PC is PC+4. The register file is not written.
- R7: Opcode 2 loads the PC with PC+4 bits [31:28], then the 26-bit field [25:0], then two zero bits.
- R8: Register 0 always reads as zero, and any write to it is discarded.
- R9: An opcode outside {0, 2, 4, 35, 43} only advances the PC by 4. It changes no register and no memory word.
- R10: While `pre_we` is 1, the PC holds and the core writes neither registers nor data memory. At each edge, `pre_data` goes to word `pre_addr` of instruction memory (`pre_sel`=0) or of data memory (`pre_sel`=1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| pre_we | input | 1 | Preload write strobe; freezes the core |
| pre_sel | input | 1 | Preload target: 0 instruction, 1 data memory |
| pre_addr | input | MEM_AW | Preload word index |
| pre_data | input | 32 | Preload word |
| pc_o | output | 32 | Current program counter |
| peek_reg | input | 5 | Register number to observe |
| peek_reg_data | output | 32 | Value of the observed register |
| peek_mem | input | MEM_AW | Data word index to observe |
| peek_mem_data | output | 32 | Value of the observed data word |

## Verification
A preload write and instruction execution can fall in the same cycle. The bench provokes this by asserting `pre_we` partway through a program, while a subtract that writes a register is the current instruction. It judges the outcome by checking three things: the PC held, the destination register stayed at zero, and the preloaded data word landed. It then releases the strobe and confirms that the same subtract completes on the next edge. A second collision lives inside the next-PC selection. A taken branch lands directly on a jump, and the exact PC on each of those edges is checked.

// File: rtl/rcore_pkg.sv
package rcore_pkg;

   localparam int XLEN = 32;
   localparam int RAW  = 5;

   localparam logic [5:0] OPC_REG  = 6'd0;
   localparam logic [5:0] OPC_JMP  = 6'd2;
   localparam logic [5:0] OPC_BEQ  = 6'd4;
   localparam logic [5:0] OPC_LOAD = 6'd35;
   localparam logic [5:0] OPC_STOR = 6'd43;

   localparam logic [5:0] FN_ADD = 6'b100000;
   localparam logic [5:0] FN_SUB = 6'b100010;
   localparam logic [5:0] FN_AND = 6'b100100;
   localparam logic [5:0] FN_OR  = 6'b100101;
   localparam logic [5:0] FN_SLT = 6'b101010;

   typedef enum logic [3:0] {
      ALU_AND = 4'b0000,
      ALU_OR  = 4'b0001,
      ALU_ADD = 4'b0010,
      ALU_SUB = 4'b0110,
      ALU_SLT = 4'b0111,
      ALU_NOR = 4'b1100
   } alu_op_e;

   typedef enum logic [1:0] {
      CLS_MEM  = 2'b00,
      CLS_BR   = 2'b01,
      CLS_REG  = 2'b10,
      CLS_NONE = 2'b11
   } op_class_e;

   typedef struct packed {
      logic      reg_write;
      logic      dst_rd;
      logic      alu_imm;
      logic      mem_write;
      logic      mem_to_reg;
      logic      branch;
      logic      jump;
      op_class_e cls;
   } ctrl_t;

endpackage

// File: rtl/rcore_decode.sv
module rcore_decode
   import rcore_pkg::*;
(
   input  logic [5:0] opcode,
   input  logic [5:0] funct,
   output ctrl_t      ctrl,
   output alu_op_e    alu_ctl
);

   always_comb begin
      ctrl = '0;
      ctrl.cls = CLS_NONE;
      unique case (opcode)
         OPC_REG: begin
            ctrl.reg_write = 1'b1;
            ctrl.dst_rd    = 1'b1;
            ctrl.cls       = CLS_REG;
         end
         OPC_LOAD: begin
            ctrl.reg_write  = 1'b1;
            ctrl.alu_imm    = 1'b1;
            ctrl.mem_to_reg = 1'b1;
            ctrl.cls        = CLS_MEM;
         end
         OPC_STOR: begin
            ctrl.alu_imm   = 1'b1;
            ctrl.mem_write = 1'b1;
            ctrl.cls       = CLS_MEM;
         end
         OPC_BEQ: begin
            ctrl.branch = 1'b1;
            ctrl.cls    = CLS_BR;
         end
         OPC_JMP: ctrl.jump = 1'b1;
         default: ;
      endcase
   end

   // second decode level: class first, then the function field
   always_comb begin
      case (ctrl.cls)
         CLS_MEM: alu_ctl = ALU_ADD;
         CLS_BR:  alu_ctl = ALU_SUB;
         CLS_REG: begin
            case (funct)
               FN_SUB:  alu_ctl = ALU_SUB;
               FN_AND:  alu_ctl = ALU_AND;
               FN_OR:   alu_ctl = ALU_OR;
               FN_SLT:  alu_ctl = ALU_SLT;
               default: alu_ctl = ALU_ADD;
            endcase
         end
         default: alu_ctl = ALU_ADD;
      endcase
   end

   // R5: stores and branches must never request a register write
   always_comb begin
      assert_store_nowrite_R5: assert (!((ctrl.mem_write || ctrl.branch) && ctrl.reg_write));
      // R9: at most one side-effect path active for any opcode
      assert_single_effect_R9: assert ($onehot0({ctrl.jump, ctrl.branch, ctrl.mem_write, ctrl.reg_write}));
   end

endmodule

// File: rtl/rcore_alu.sv
module rcore_alu
   import rcore_pkg::*;
#(
   parameter int W = 32
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  alu_op_e      op,
   output logic [W-1:0] y,
   output logic         zero
);

   if (W < 2) begin : g_bad_w
      $error("rcore_alu: W must be at least 2");
   end

   logic lt_signed;
   assign lt_signed = $signed(a) < $signed(b);

   always_comb begin
      case (op)
         ALU_AND: y = a & b;
         ALU_OR:  y = a | b;
         ALU_ADD: y = a + b;
         ALU_SUB: y = a - b;
         ALU_SLT: y = {{(W-1){1'b0}}, lt_signed};
         ALU_NOR: y = ~(a | b);
         default: y = '0;
      endcase
   end

   assign zero = (y == '0);

endmodule

// File: rtl/rcore_regfile.sv
module rcore_regfile #(
   parameter int W  = 32,
   parameter int AW = 5
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          we,
   input  logic [AW-1:0] wa,
   input  logic [W-1:0]  wd,
   input  logic [AW-1:0] ra1,
   input  logic [AW-1:0] ra2,
   input  logic [AW-1:0] ra3,
   output logic [W-1:0]  rd1,
   output logic [W-1:0]  rd2,
   output logic [W-1:0]  rd3
);

   localparam int NREG = 1 << AW;

   if (AW < 1 || AW > 6) begin : g_bad_aw
      $error("rcore_regfile: AW out of range");
   end

   logic [W-1:0] regs [NREG];

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      if (i == 0) begin : g_zero
         assign regs[i] = '0;
      end else begin : g_store
         always_ff @(posedge clk) begin
            if (rst)
               regs[i] <= '0;
            else if (we && wa == AW'(i))
               regs[i] <= wd;
         end
      end
   end

   assign rd1 = regs[ra1];
   assign rd2 = regs[ra2];
   assign rd3 = regs[ra3];

   // R8: a write aimed at register 0 leaves it reading zero afterwards
   assert_r0_sticky_R8: assert property (@(posedge clk) disable iff (rst)
      (we && wa == '0 && ra3 == '0) |=> (ra3 != '0 || rd3 == '0));

endmodule

// File: rtl/rcore_dmem.sv
module rcore_dmem #(
   parameter int W  = 32,
   parameter int AW = 8
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic [AW-1:0] raddr_a,
   input  logic [AW-1:0] raddr_b,
   output logic [W-1:0]  rdata_a,
   output logic [W-1:0]  rdata_b
);

   localparam int DEPTH = 1 << AW;

   logic [W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata_a = mem[raddr_a];
   assign rdata_b = mem[raddr_b];

endmodule

// File: rtl/rcore_top.sv
module rcore_top
   import rcore_pkg::*;
#(
   parameter int MEM_AW = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              pre_we,
   input  logic              pre_sel,
   input  logic [MEM_AW-1:0] pre_addr,
   input  logic [31:0]       pre_data,
   output logic [31:0]       pc_o,
   input  logic [4:0]        peek_reg,
   output logic [31:0]       peek_reg_data,
   input  logic [MEM_AW-1:0] peek_mem,
   output logic [31:0]       peek_mem_data
);

   localparam int IDEPTH = 1 << MEM_AW;
   localparam int IDX_HI = MEM_AW + 1;

   if (MEM_AW < 2 || MEM_AW > 12) begin : g_bad_mem
      $error("rcore_top: MEM_AW must lie in 2..12");
   end

   logic [XLEN-1:0] pc, pc_plus4, br_target, jmp_target, pc_next;
   logic [XLEN-1:0] instr, simm, rs_val, rt_val, alu_b, alu_y, dm_rd, wb_data;
   logic [4:0]      wa;
   logic            zero, take_br, run;
   ctrl_t           ctrl;
   alu_op_e         alu_ctl;

   // instruction memory
   logic [XLEN-1:0] imem [IDEPTH];
   always_ff @(posedge clk) begin
      if (pre_we && !pre_sel) imem[pre_addr] <= pre_data;
   end
   assign instr = imem[pc[IDX_HI:2]];

   assign run = !pre_we;

   rcore_decode u_dec (
      .opcode  (instr[31:26]),
      .funct   (instr[5:0]),
      .ctrl    (ctrl),
      .alu_ctl (alu_ctl)
   );

   assign wa = ctrl.dst_rd ? instr[15:11] : instr[20:16];

   rcore_regfile #(.W(XLEN), .AW(RAW)) u_rf (
      .clk (clk),
      .rst (rst),
      .we  (ctrl.reg_write && run),
      .wa  (wa),
      .wd  (wb_data),
      .ra1 (instr[25:21]),
      .ra2 (instr[20:16]),
      .ra3 (peek_reg),
      .rd1 (rs_val),
      .rd2 (rt_val),
      .rd3 (peek_reg_data)
   );

   assign simm  = {{16{instr[15]}}, instr[15:0]};
   assign alu_b = ctrl.alu_imm ? simm : rt_val;

   rcore_alu #(.W(XLEN)) u_alu (
      .a    (rs_val),
      .b    (alu_b),
      .op   (alu_ctl),
      .y    (alu_y),
      .zero (zero)
   );

   rcore_dmem #(.W(XLEN), .AW(MEM_AW)) u_dmem (
      .clk     (clk),
      .we      (pre_we ? pre_sel : ctrl.mem_write),
      .waddr   (pre_we ? pre_addr : alu_y[IDX_HI:2]),
      .wdata   (pre_we ? pre_data : rt_val),
      .raddr_a (alu_y[IDX_HI:2]),
      .raddr_b (peek_mem),
      .rdata_a (dm_rd),
      .rdata_b (peek_mem_data)
   );

   assign wb_data = ctrl.mem_to_reg ? dm_rd : alu_y;

   // next-PC selection
   assign pc_plus4   = pc + 32'd4;
   assign br_target  = pc_plus4 + {simm[XLEN-3:0], 2'b00};
   assign jmp_target = {pc_plus4[31:28], instr[25:0], 2'b00};
   assign take_br    = ctrl.branch && zero;

   always_comb begin
      if (ctrl.jump)    pc_next = jmp_target;
      else if (take_br) pc_next = br_target;
      else              pc_next = pc_plus4;
   end

   always_ff @(posedge clk) begin
      if (rst)      pc <= '0;
      else if (run) pc <= pc_next;
   end

   assign pc_o = pc;

   logic unused_bits;
   assign unused_bits = ^{instr[10:6], alu_y[XLEN-1:IDX_HI+1], alu_y[1:0],
                          pc[XLEN-1:IDX_HI+1], pc[1:0], ctrl.cls};

   // R2: sequential instructions step the PC by four
   assert_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(run) && !$past(ctrl.jump) && !$past(take_br))
         |-> pc == $past(pc) + 32'd4);

   // R10: preload freezes the PC
   assert_pc_hold_R10: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(pre_we)) |-> $stable(pc));

   // R7: a jump keeps the upper PC+4 nibble and lands word aligned
   assert_jump_align_R7: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(run) && $past(ctrl.jump))
         |-> (pc[1:0] == 2'b00 && pc[31:28] == $past(pc_plus4[31:28])));

endmodule

// File: tb/rcore_top_tb_top.sv
`timescale 1ns/1ps
module rcore_top_tb_top;

   localparam int AW = 8;

   logic          clk = 1'b0;
   logic          rst;
   logic          pre_we, pre_sel;
   logic [AW-1:0] pre_addr;
   logic [31:0]   pre_data;
   logic [31:0]   pc_o;
   logic [4:0]    peek_reg;
   logic [31:0]   peek_reg_data;
   logic [AW-1:0] peek_mem;
   logic [31:0]   peek_mem_data;

   int total = 0;
   int bad   = 0;

   always #2.5 clk = ~clk;

   rcore_top #(.MEM_AW(AW)) dut_i (
      .clk (clk), .rst (rst),
      .pre_we (pre_we), .pre_sel (pre_sel), .pre_addr (pre_addr), .pre_data (pre_data),
      .pc_o (pc_o),
      .peek_reg (peek_reg), .peek_reg_data (peek_reg_data),
      .peek_mem (peek_mem), .peek_mem_data (peek_mem_data)
   );

   function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
      return {6'd0, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
   endfunction
   function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
      return {op, rs[4:0], rt[4:0], imm[15:0]};
   endfunction
   function automatic logic [31:0] enc_j(int tgt);
      return {6'd2, tgt[25:0]};
   endfunction

   localparam int NPROG = 23;
   localparam logic [31:0] PROG [NPROG] = '{
      enc_i(6'd35, 0, 1, 0),          // 0  lw r1,0(r0)
      enc_i(6'd35, 0, 2, 4),          // 1  lw r2,4(r0)
      enc_r(1, 2, 3, 6'b100000),      // 2  add r3
      enc_r(1, 2, 4, 6'b100010),      // 3  sub r4
      enc_r(1, 2, 5, 6'b100100),      // 4  and r5
      enc_r(1, 2, 6, 6'b100101),      // 5  or r6
      enc_r(1, 2, 7, 6'b101010),      // 6  slt r7
      enc_i(6'd35, 0, 8, 8),          // 7  lw r8,8(r0)
      enc_r(8, 1, 9, 6'b101010),      // 8  slt r9 (-3<5)
      enc_r(1, 8, 10, 6'b101010),     // 9  slt r10 (5<-3)
      enc_i(6'd43, 0, 3, 12),         // 10 sw r3,12(r0)
      enc_r(1, 2, 0, 6'b100000),      // 11 add r0 (discarded)
      enc_i(6'd4, 1, 2, 5),           // 12 beq not taken
      enc_i(6'd4, 1, 1, 2),           // 13 beq taken -> 16
      enc_r(1, 1, 11, 6'b100000),     // 14 skipped
      enc_r(1, 1, 11, 6'b100000),     // 15 skipped
      enc_j(20),                      // 16 j -> 20
      enc_r(1, 1, 12, 6'b100000),     // 17 skipped
      enc_r(1, 1, 13, 6'b100000),     // 18 skipped
      enc_r(1, 1, 13, 6'b100000),     // 19 skipped
      enc_i(6'h3F, 1, 12, 4),         // 20 unsupported opcode
      enc_i(6'd43, 3, 4, -4),         // 21 sw r4,-4(r3)
      enc_i(6'd4, 0, 0, -1)           // 22 beq self loop
   };

   // {requirement number, is_mem, address, expected value}
   localparam int NEXP = 17;
   localparam logic [44:0] EXPV [NEXP] = '{
      {4'd5, 1'b0, 8'd1,  32'd5},          // R5 load
      {4'd5, 1'b0, 8'd2,  32'd7},          // R5 load
      {4'd3, 1'b0, 8'd3,  32'd12},         // R3 add
      {4'd3, 1'b0, 8'd4,  32'hFFFF_FFFE},  // R3 sub
      {4'd3, 1'b0, 8'd5,  32'd5},          // R3 and
      {4'd3, 1'b0, 8'd6,  32'd7},          // R3 or
      {4'd4, 1'b0, 8'd7,  32'd1},          // R4 slt
      {4'd5, 1'b0, 8'd8,  32'hFFFF_FFFD},  // R5 load negative
      {4'd4, 1'b0, 8'd9,  32'd1},          // R4 signed less
      {4'd4, 1'b0, 8'd10, 32'd0},          // R4 signed not less
      {4'd8, 1'b0, 8'd0,  32'd0},          // R8 r0 write ignored
      {4'd6, 1'b0, 8'd11, 32'd0},          // R6 branch shadow skipped
      {4'd9, 1'b0, 8'd12, 32'd0},          // R9 no-op wrote nothing, R7 skip
      {4'd7, 1'b0, 8'd13, 32'd0},          // R7 jump shadow skipped
      {4'd5, 1'b1, 8'd3,  32'd12},         // R5 store
      {4'd5, 1'b1, 8'd2,  32'hFFFF_FFFE},  // R5 store negative offset
      {4'd9, 1'b1, 8'd0,  32'd5}           // R9 memory untouched
   };

   task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
      end
   endtask

   task automatic step(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic preload(logic sel, int addr, logic [31:0] data);
      pre_we = 1'b1; pre_sel = sel; pre_addr = AW'(addr); pre_data = data;
      step(1);
   endtask

   task automatic reg_val(int r, output logic [31:0] v);
      peek_reg = r[4:0]; #0.5; v = peek_reg_data;
   endtask

   initial begin
      #200000;
      bad++; total++;
      $display("FAIL watchdog R1..all act=hang exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [31:0] v;
      rst = 1'b1; pre_we = 1'b0; pre_sel = 1'b0; pre_addr = '0; pre_data = '0;
      peek_reg = '0; peek_mem = '0;
      step(2);
      for (int i = 0; i < NPROG; i++) preload(1'b0, i, PROG[i]);
      preload(1'b1, 0, 32'd5);
      preload(1'b1, 1, 32'd7);
      preload(1'b1, 2, 32'hFFFF_FFFD);
      preload(1'b1, 3, 32'd0);
      pre_we = 1'b0;
      step(1);
      check("R1", pc_o, 32'd0, "pc after reset");
      reg_val(5, v);
      check("R1", v, 32'd0, "reg5 after reset");

      rst = 1'b0;
      step(1);
      check("R2", pc_o, 32'd4, "pc step one");
      step(12);
      check("R6", pc_o, 32'd52, "pc after untaken beq");
      step(1);
      check("R6", pc_o, 32'd64, "pc after taken beq");
      step(1);
      check("R7", pc_o, 32'd80, "pc after jump");
      step(1);
      check("R9", pc_o, 32'd84, "pc after no-op");
      step(1);
      check("R2", pc_o, 32'd88, "pc after store");
      step(20);
      check("R6", pc_o, 32'd88, "self loop holds");

      for (int k = 0; k < NEXP; k++) begin
         if (EXPV[k][40]) begin
            peek_mem = EXPV[k][39:32]; #0.5; v = peek_mem_data;
         end else begin
            reg_val(int'(EXPV[k][39:32]), v);
         end
         check($sformatf("R%0d", EXPV[k][44:41]), v, EXPV[k][31:0],
               $sformatf("entry %0d", k));
      end

      // R10: preload collides with a register-writing instruction
      rst = 1'b1; step(1);
      rst = 1'b0; step(3);
      check("R10", pc_o, 32'd12, "pc before freeze");
      preload(1'b1, 10, 32'h0000_ABCD);
      preload(1'b1, 11, 32'h0000_1234);
      check("R10", pc_o, 32'd12, "pc frozen");
      reg_val(4, v);
      check("R10", v, 32'd0, "reg4 untouched during freeze");
      peek_mem = 8'd10; #0.5;
      check("R10", peek_mem_data, 32'h0000_ABCD, "dmem preload landed");
      pre_we = 1'b0;
      step(1);
      check("R10", pc_o, 32'd16, "pc resumes");
      reg_val(4, v);
      check("R3", v, 32'hFFFF_FFFE, "sub completes after freeze");
      reg_val(3, v);
      check("R1", v, 32'd12, "reg3 rebuilt after second reset");

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule